// File: doc/BRIEF.md
# Rotate-and-Mask Field Unit

This unit merges a bit field of one 32-bit word into another. It takes an A word, an M word, a 5-bit rotate amount, a 5-bit length code and two mode bits. The M word may be rotated and a contiguous mask may be rotated, each under its own mode bit. The result takes the rotated M bits where the mask is set and the A bits everywhere else. One datapath therefore covers three field operations. It can pull a field down to the low end, copy a field of M into the same place in A, and drop the low field of M into A at a chosen position.

A byte-operation strobe chooses between this merged word and an ALU word on the output, so a byte operation always puts this unit's result on the output. A second output gives a field of up to 8 bits from the low end of the rotated M word, cut to the mask length, for use as a dispatch index. With the default build both outputs are registered and appear one clock after the inputs.

Top module: `rotmask_unit`

## Requirements
- R1: With `byte_op`=1 the result is (rotM AND mask) OR (A AND NOT mask). rotM is M rotated left by `rot_amt` when `sr_mode`=1, or M unchanged when `sr_mode`=0.
- R2: The mask holds `len_code`+1 ones starting at bit 0. When `mr_mode`=1 it is rotated left by `rot_amt` and wraps from bit 31 to bit 0. When `mr_mode`=0 it is not rotated. With both mode bits 0 and `len_code`=0, only bit 0 of the result comes from M.
- R3: Extraction (`sr_mode`=1, `mr_mode`=0): setting `rot_amt` = (32 − p) mod 32 moves the field that starts at bit p of M down to bit 0. All bits above the field come from A.
- R4: Selective copy (`sr_mode`=0, `mr_mode`=1): M bits `rot_amt` .. `rot_amt`+`len_code` (mod 32) replace the same bits of A.
- R5: Deposit (`sr_mode`=1, `mr_mode`=1): the low `len_code`+1 bits of M are placed in A starting at bit `rot_amt`.
- R6: With `byte_op`=0 the result equals `alu_word`, whatever the other inputs are.
- R7: `disp_field` bit i (0..7) equals bit i of rotM when i ≤ `len_code`, and is 0 otherwise. It does not depend on `byte_op` or `mr_mode`.
- R8: Both outputs are registered. They show the values for the inputs present at the previous rising clock edge. While `rst_n` is low they are 0.
- R9: With `len_code`=31 the mask is all ones and the result equals rotM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_word | input | 32 | Word that supplies the unmasked bits |
| m_word | input | 32 | Word that supplies the field |
| alu_word | input | 32 | Word passed to the output when no byte operation is present |
| rot_amt | input | 5 | Rotate amount, left |
| len_code | input | 5 | Field length minus one |
| sr_mode | input | 1 | Rotate M by `rot_amt` when 1 |
| mr_mode | input | 1 | Rotate the mask by `rot_amt` when 1 |
| byte_op | input | 1 | Selects the merged word on `res_word` |
| res_word | output | 32 | Merged word or ALU word |
| disp_field | output | 8 | Low field of rotated M, cut to the mask length |

## Verification
Every combination of length and rotate amount is tried in each of the four mode settings, with fresh random A and M words each time. This separates errors in mask length from errors in mask position, and shows whether a fault lies in the M rotation or in the mask rotation. Directed cases with all-ones and all-zero words expose a mask that wraps past bit 31. A single known byte shows whether extraction and deposit move the field in the right direction. Cycles with the byte-operation strobe low and varied field inputs show that only the ALU word reaches the output.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
    parameter int unsigned RMU_DW    = 32;
    parameter int unsigned RMU_DISPW = 8;
    parameter bit          RMU_REG   = 1'b1;
endpackage

// File: rtl/rmu_rotl.sv
module rmu_rotl #(
    parameter int unsigned DW = rmu_pkg::RMU_DW,
    localparam int unsigned CW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] amt,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stage [0:CW];

    assign stage[0] = din;

    // one conditional rotate per amount bit, by 2**s
    for (genvar s = 0; s < CW; s++) begin : g_stage
        localparam int unsigned SH = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][DW-1-SH:0], stage[s][DW-1:DW-SH]}
                                   : stage[s];
    end

    assign dout = stage[CW];
endmodule

// File: rtl/rmu_maskgen.sv
module rmu_maskgen #(
    parameter int unsigned DW = rmu_pkg::RMU_DW,
    localparam int unsigned CW = $clog2(DW)
) (
    input  logic [CW-1:0] len_code,
    input  logic [CW-1:0] rot_amt,
    input  logic          rot_en,
    output logic [DW-1:0] low_mask,
    output logic [DW-1:0] mask
);
    logic [CW-1:0] eff_amt;

    // thermometer: bit i set when i <= len_code
    for (genvar i = 0; i < DW; i++) begin : g_therm
        assign low_mask[i] = (i <= int'(len_code));
    end

    assign eff_amt = rot_en ? rot_amt : '0;

    rmu_rotl #(.DW(DW)) u_mrot (
        .din  (low_mask),
        .amt  (eff_amt),
        .dout (mask)
    );
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
    parameter int unsigned DW      = rmu_pkg::RMU_DW,
    parameter int unsigned DISPW   = rmu_pkg::RMU_DISPW,
    parameter bit          REG_OUT = rmu_pkg::RMU_REG,
    localparam int unsigned CW = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    a_word,
    input  logic [DW-1:0]    m_word,
    input  logic [DW-1:0]    alu_word,
    input  logic [CW-1:0]    rot_amt,
    input  logic [CW-1:0]    len_code,
    input  logic             sr_mode,
    input  logic             mr_mode,
    input  logic             byte_op,
    output logic [DW-1:0]    res_word,
    output logic [DISPW-1:0] disp_field
);
    logic [CW-1:0]    m_amt;
    logic [DW-1:0]    rot_m;
    logic [DW-1:0]    low_mask;
    logic [DW-1:0]    mask;
    logic [DW-1:0]    merged;
    logic [DW-1:0]    res_nxt;
    logic [DISPW-1:0] disp_nxt;

    assign m_amt = sr_mode ? rot_amt : '0;

    rmu_rotl #(.DW(DW)) u_drot (
        .din  (m_word),
        .amt  (m_amt),
        .dout (rot_m)
    );

    rmu_maskgen #(.DW(DW)) u_mask (
        .len_code (len_code),
        .rot_amt  (rot_amt),
        .rot_en   (mr_mode),
        .low_mask (low_mask),
        .mask     (mask)
    );

    assign merged   = (rot_m & mask) | (a_word & ~mask);
    assign res_nxt  = byte_op ? merged : alu_word;
    assign disp_nxt = rot_m[DISPW-1:0] & low_mask[DISPW-1:0];

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_word   <= '0;
                disp_field <= '0;
            end else begin
                res_word   <= res_nxt;
                disp_field <= disp_nxt;
            end
        end
    end else begin : g_comb
        assign res_word   = res_nxt;
        assign disp_field = disp_nxt;
    end
endmodule

module rmu_chk #(
    parameter int unsigned DW      = 32,
    parameter int unsigned DISPW   = 8,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned CW = $clog2(DW)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DW-1:0]    a_word,
    input logic [DW-1:0]    m_word,
    input logic [DW-1:0]    alu_word,
    input logic [CW-1:0]    rot_amt,
    input logic [CW-1:0]    len_code,
    input logic             sr_mode,
    input logic             mr_mode,
    input logic             byte_op,
    input logic [DW-1:0]    res_word,
    input logic [DISPW-1:0] disp_field
);
    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    if (REG_OUT) begin : g_props
        AST_ALU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (live && !$past(byte_op)) |-> (res_word == $past(alu_word))); // R6

        AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (live && $past(byte_op) && $past(len_code) == CW'(DW-1)
                  && (!$past(sr_mode) || $past(rot_amt) == '0))
            |-> (res_word == $past(m_word))); // R9

        AST_SINGLE_BIT_KEEP_A: assert property (@(posedge clk) disable iff (!rst_n)
            (live && $past(byte_op) && !$past(sr_mode) && !$past(mr_mode)
                  && $past(len_code) == '0)
            |-> (res_word == {$past(a_word[DW-1:1]), $past(m_word[0])})); // R2

        AST_DISP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (live && $past(len_code) == '0) |-> (disp_field[DISPW-1:1] == '0)); // R7

        AST_DISP_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (live && !$past(sr_mode)) |-> (disp_field[0] == $past(m_word[0]))); // R7
    end
endmodule

bind rotmask_unit rmu_chk #(.DW(DW), .DISPW(DISPW), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_rotmask_unit.sv
module sim_rotmask_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_word = '0, m_word = '0, alu_word = '0;
    logic [4:0]  rot_amt = '0, len_code = '0;
    logic        sr_mode = 1'b0, mr_mode = 1'b0, byte_op = 1'b0;
    logic [31:0] res_word;
    logic [7:0]  disp_field;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    rotmask_unit u0 (
        .clk(clk), .rst_n(rst_n), .a_word(a_word), .m_word(m_word),
        .alu_word(alu_word), .rot_amt(rot_amt), .len_code(len_code),
        .sr_mode(sr_mode), .mr_mode(mr_mode), .byte_op(byte_op),
        .res_word(res_word), .disp_field(disp_field)
    );

    function automatic logic [31:0] ref_rotl(input logic [31:0] x, input int r);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[(i + r) % 32] = x[i];
        return y;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // drive at falling edge, let one rising edge register, compare at next falling edge
    task automatic apply(input string tag, input logic [31:0] a, input logic [31:0] m,
                         input logic [31:0] alu, input int rot, input int len,
                         input bit sr, input bit mr, input bit bop);
        logic [31:0] rm, lm, mk, exp_res;
        logic [7:0]  exp_disp;
        a_word = a; m_word = m; alu_word = alu;
        rot_amt = 5'(rot); len_code = 5'(len);
        sr_mode = sr; mr_mode = mr; byte_op = bop;
        rm = ref_rotl(m, sr ? rot : 0);
        lm = '0;
        for (int i = 0; i <= len; i++) lm[i] = 1'b1;
        mk = ref_rotl(lm, mr ? rot : 0);
        exp_res = bop ? ((rm & mk) | (a & ~mk)) : alu;
        exp_disp = '0;
        for (int i = 0; i < 8; i++) if (i <= len) exp_disp[i] = rm[i];
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 result"}, res_word, exp_res);
        check("R7 disp", {24'd0, disp_field}, {24'd0, exp_disp});
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        a_word = 32'hDEAD_BEEF; m_word = 32'h1234_5678; alu_word = 32'hCAFE_F00D;
        byte_op = 1'b1; sr_mode = 1'b1; mr_mode = 1'b1; len_code = 5'd7;
        repeat (3) @(negedge clk);
        check("R8 reset res", res_word, 32'h0);
        check("R8 reset disp", {24'd0, disp_field}, 32'h0);
        rst_n = 1'b1;

        // directed field moves
        apply("R3 extract byte at 8", 32'hFFFF_FFFF, 32'hABCD_1234, 0, 24, 7, 1, 0, 1);
        check("R3 extract value", res_word, 32'hFFFF_FF12);
        apply("R5 deposit byte at 16", 32'h0, 32'h0000_005A, 0, 16, 7, 1, 1, 1);
        check("R5 deposit value", res_word, 32'h005A_0000);
        apply("R4 copy top nibble", 32'h0, 32'hFFFF_FFFF, 0, 28, 3, 0, 1, 1);
        check("R4 copy value", res_word, 32'hF000_0000);
        apply("R2 wrapped mask", 32'h0, 32'hFFFF_FFFF, 0, 28, 7, 0, 1, 1);
        check("R2 wrap value", res_word, 32'hF000_000F);
        apply("R9 full mask", 32'h0, 32'h8000_0001, 0, 4, 31, 1, 0, 1);
        check("R9 full value", res_word, 32'h0000_0018);

        // ALU pass-through with varied field inputs
        for (int k = 0; k < 16; k++)
            apply("R6 alu pass", $urandom, $urandom, $urandom, k * 2, 31 - k,
                  k[0], k[1], 0);

        // exhaustive length x rotate per mode
        for (int md = 0; md < 4; md++) begin
            for (int len = 0; len < 32; len++) begin
                for (int rot = 0; rot < 32; rot++) begin
                    string tg;
                    bit sr, mr;
                    sr = md[0]; mr = md[1];
                    if (len == 31)      tg = "R1 R9 full";
                    else if (sr && !mr) tg = "R1 R3 extract";
                    else if (!sr && mr) tg = "R1 R4 copy";
                    else if (sr && mr)  tg = "R1 R5 deposit";
                    else                tg = "R1 R2 fixed mask";
                    apply(tg, $urandom, $urandom, $urandom, rot, len, sr, mr, 1);
                end
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule